// File: doc/BRIEF.md
# Pulse Timestamp Capture Queues

This block keeps a separate first-in, first-out record for each of several output channels. Each record holds the time at which that channel produced a pulse. When a channel's one-cycle strobe is high, the block stores the wide seconds value and the sub-second cycle count present on the time-base inputs in that cycle. Software reads the records through a small word-addressed register port. Each record comes out in three reads: the low seconds word, the high seconds word and the cycle word. The read of the cycle word removes the record. A per-channel status word gives the fill level and an overflow flag.

A single level interrupt tells software that records are waiting. Each channel has an enable bit. The interrupt line is high while any enabled channel holds at least one record. Two read-only views show the enables and the channels that hold data, so an interrupt handler can find which queues to drain. The handler reads each queue until its count falls to zero.

Top module: `pulse_stamp_fifos`

## Requirements
- R1: When `pulse_i[c]` is high at a rising clock edge, channel c appends one record holding `tb_sec_i` and `tb_cyc_i` from that same cycle. A strobe on one channel does not change the record or the count of any other channel.
- R2: The word at channel offset 0xC reads the channel's record count in bits [7:0] and its overflow flag in bit 8. All other bits read zero. Channel c's four-word block starts at byte address 0x10*(c+1). Bits [3:2] of the address select the word.
- R3: A read of offset 0x0 returns seconds bits [31:0] of the oldest record and captures that whole record. A later read of offset 0x4 returns the captured seconds bits above bit 31, zero-extended. A read of offset 0x8 returns the captured cycle count, zero-extended, and removes the oldest record. Records leave in the order they arrived.
- R4: The count never exceeds DEPTH. A strobe that arrives while the queue is full is dropped and sets the sticky overflow flag. Only a write with bit 8 set to the channel's status word clears the flag.
- R5: A write to address 0x00 loads the per-channel interrupt enables from the low NUM_CH data bits. Reading 0x04 returns those enables. Reading 0x08 returns one bit per channel that is high while that channel's queue is non-empty.
- R6: `irq_o` is high exactly while some channel is both enabled and non-empty. It falls once the last enabled non-empty queue is drained or disabled.
- R7: Strobes on consecutive clock cycles on one channel are all stored and read back in arrival order with their distinct stamps.
- R8: After reset every queue is empty, the overflow flags and enables are zero, `irq_o` is low and `reg_rdata_o` is zero.
- R9: Reading a record from an empty queue returns zero in all three words and leaves the count at zero.
- R10: When a queue is full, a removal and a new strobe in the same cycle are both accepted. The count stays at DEPTH and the overflow flag stays clear.
- R11: Read data appears on `reg_rdata_o` in the cycle after `reg_rd_i` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_i | input | NUM_CH | One-cycle pulse strobe per channel |
| tb_sec_i | input | SEC_W | Time base, whole seconds |
| tb_cyc_i | input | CYC_W | Time base, cycle count within the second |
| reg_addr_i | input | ADDR_W | Byte address of the register access |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rd_i | input | 1 | Read strobe |
| reg_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt request |

## Verification
The embedded properties watch the following on every cycle:
- A queue's count never passes its depth.
- A strobe refused by a full queue leaves the count unchanged and sets the overflow flag.
- An accepted strobe without a removal adds exactly one record.
- A removal from an empty queue leaves it empty.
- The interrupt stays low with every enable clear and holds while its inputs are steady.

Only the bench's scenarios can show the rest:
- The stamps come back correct and in order, including back-to-back strobes and a same-cycle removal and strobe on a full queue.
- The three-word read of a record is consistent.
- The overflow flag clears only on a write.
- Channels stay independent of one another.

// File: rtl/pst_pkg.sv
package pst_pkg;

    // Word select within a channel block (address bits [3:2])
    typedef enum logic [1:0] {
        WORD_SEC_LO = 2'd0,
        WORD_SEC_HI = 2'd1,
        WORD_CYC    = 2'd2,
        WORD_STAT   = 2'd3
    } word_e;

    // Word select within the global block (block index zero)
    typedef enum logic [1:0] {
        GREG_ENABLE = 2'd0,
        GREG_MASK   = 2'd1,
        GREG_PEND   = 2'd2,
        GREG_RSVD   = 2'd3
    } greg_e;

    localparam int OVF_BIT     = 8;
    localparam int CNT_FIELD_W = 8;
    localparam int BLK_W       = 4;

endpackage

// File: rtl/pst_chan_fifo.sv
module pst_chan_fifo #(
    parameter int DEPTH = 16,
    parameter int SEC_W = 40,
    parameter int CYC_W = 28
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push_i,
    input  logic [SEC_W-1:0] sec_i,
    input  logic [CYC_W-1:0] cyc_i,
    input  logic        latch_i,
    input  logic        pop_i,
    input  logic        ovf_clr_i,
    output logic [31:0] head_sec_lo_o,
    output logic [31:0] snap_sec_hi_o,
    output logic [31:0] snap_cyc_o,
    output logic [7:0]  count_o,
    output logic        ovf_o,
    output logic        nonempty_o
);
    import pst_pkg::*;

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int HI_W  = SEC_W - 32;

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] count;
        logic             ovf;
        logic [HI_W-1:0]  snap_hi;
        logic [CYC_W-1:0] snap_cyc;
    } st_t;

    st_t st_d, st_q;

    logic [SEC_W-1:0] mem_sec [DEPTH];
    logic [CYC_W-1:0] mem_cyc [DEPTH];

    logic             empty, full, do_pop, do_push;
    logic [SEC_W-1:0] head_sec;
    logic [CYC_W-1:0] head_cyc;

    function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d     = st_q;
        empty    = (st_q.count == '0);
        full     = (st_q.count == CNT_W'(DEPTH));
        do_pop   = pop_i && !empty;
        do_push  = push_i && (!full || do_pop);
        head_sec = empty ? '0 : mem_sec[st_q.rptr];
        head_cyc = empty ? '0 : mem_cyc[st_q.rptr];

        if (do_push) st_d.wptr = adv(st_q.wptr);
        if (do_pop)  st_d.rptr = adv(st_q.rptr);

        if (do_push && !do_pop)
            st_d.count = st_q.count + 1'b1;
        else if (do_pop && !do_push)
            st_d.count = st_q.count - 1'b1;

        if (ovf_clr_i)          st_d.ovf = 1'b0;
        if (push_i && !do_push) st_d.ovf = 1'b1;

        if (latch_i) begin
            st_d.snap_hi  = head_sec[SEC_W-1:32];
            st_d.snap_cyc = head_cyc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem_sec[st_q.wptr] <= sec_i;
            mem_cyc[st_q.wptr] <= cyc_i;
        end
    end

    assign head_sec_lo_o = head_sec[31:0];
    assign snap_sec_hi_o = 32'(st_q.snap_hi);
    assign snap_cyc_o    = 32'(st_q.snap_cyc);
    assign count_o       = CNT_FIELD_W'(st_q.count);
    assign ovf_o         = st_q.ovf;
    assign nonempty_o    = !empty;

    // R4
    count_le_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CNT_W'(DEPTH));

    // R4
    drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full && !pop_i) |=> (st_q.ovf && $stable(st_q.count)));

    // R1
    push_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !full && !pop_i) |=> (st_q.count == ($past(st_q.count) + CNT_W'(1))));

    // R9
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty && !push_i) |=> (st_q.count == '0));

endmodule

// File: rtl/pst_irq_ctrl.sv
module pst_irq_ctrl #(
    parameter int NUM_CH = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_we_i,
    input  logic [NUM_CH-1:0] en_wdata_i,
    input  logic [NUM_CH-1:0] nonempty_i,
    output logic [NUM_CH-1:0] mask_o,
    output logic [NUM_CH-1:0] pend_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] en;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_we_i) st_d.en = en_wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_o = st_q.en;
    assign pend_o = nonempty_i;
    assign irq_o  = |(st_q.en & nonempty_i);

    // R6
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en == '0) |-> !irq_o);

    // R6
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !en_we_i) |=> (irq_o || ($past(nonempty_i) != nonempty_i)));

endmodule

// File: rtl/pst_reg_decode.sv
module pst_reg_decode #(
    parameter int NUM_CH = 5,
    parameter int ADDR_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd_i,
    input  logic                   wr_i,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [31:0]            wdata_i,
    input  logic [NUM_CH-1:0][31:0] head_lo_i,
    input  logic [NUM_CH-1:0][31:0] snap_hi_i,
    input  logic [NUM_CH-1:0][31:0] snap_cyc_i,
    input  logic [NUM_CH-1:0][7:0]  count_i,
    input  logic [NUM_CH-1:0]      ovf_i,
    input  logic [NUM_CH-1:0]      mask_i,
    input  logic [NUM_CH-1:0]      pend_i,
    output logic [NUM_CH-1:0]      latch_o,
    output logic [NUM_CH-1:0]      pop_o,
    output logic [NUM_CH-1:0]      ovf_clr_o,
    output logic                   en_we_o,
    output logic [NUM_CH-1:0]      en_wdata_o,
    output logic [31:0]            rdata_o
);
    import pst_pkg::*;

    typedef struct packed {
        logic [31:0] rdata;
    } st_t;

    st_t st_d, st_q;

    logic [BLK_W-1:0] blk;
    logic [1:0]       word;
    logic [31:0]      rd_val;
    logic             unused_bits;

    assign blk         = addr_i[7:4];
    assign word        = addr_i[3:2];
    assign unused_bits = ^{addr_i[1:0], wdata_i};

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_dec
            logic sel;
            assign sel          = (blk == BLK_W'(g + 1));
            assign latch_o[g]   = rd_i && sel && (word == WORD_SEC_LO);
            assign pop_o[g]     = rd_i && sel && (word == WORD_CYC);
            assign ovf_clr_o[g] = wr_i && sel && (word == WORD_STAT) && wdata_i[OVF_BIT];
        end
    endgenerate

    assign en_we_o    = wr_i && (blk == '0) && (word == GREG_ENABLE);
    assign en_wdata_o = wdata_i[NUM_CH-1:0];

    always_comb begin
        st_d   = st_q;
        rd_val = '0;
        if (blk == '0) begin
            case (word)
                GREG_MASK: rd_val = 32'(mask_i);
                GREG_PEND: rd_val = 32'(pend_i);
                default:   rd_val = '0;
            endcase
        end
        for (int c = 0; c < NUM_CH; c++) begin
            if (blk == BLK_W'(c + 1)) begin
                case (word)
                    WORD_SEC_LO: rd_val = head_lo_i[c];
                    WORD_SEC_HI: rd_val = snap_hi_i[c];
                    WORD_CYC:    rd_val = snap_cyc_i[c];
                    default:     rd_val = {23'b0, ovf_i[c], count_i[c]};
                endcase
            end
        end
        if (rd_i) st_d.rdata = rd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata_o = st_q.rdata;

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rdata_o));

endmodule

// File: rtl/pulse_stamp_fifos.sv
module pulse_stamp_fifos #(
    parameter int NUM_CH = 5,
    parameter int DEPTH  = 16,
    parameter int SEC_W  = 40,
    parameter int CYC_W  = 28,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pulse_i,
    input  logic [SEC_W-1:0]  tb_sec_i,
    input  logic [CYC_W-1:0]  tb_cyc_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic [31:0]       reg_wdata_i,
    input  logic              reg_rd_i,
    output logic [31:0]       reg_rdata_o,
    output logic              irq_o
);
    logic [NUM_CH-1:0][31:0] head_lo, snap_hi, snap_cyc;
    logic [NUM_CH-1:0][7:0]  cnt;
    logic [NUM_CH-1:0]       ovf, nonempty, latch, pop, ovf_clr, mask, pend, en_wdata;
    logic                    en_we;

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_ch
            pst_chan_fifo #(
                .DEPTH (DEPTH),
                .SEC_W (SEC_W),
                .CYC_W (CYC_W)
            ) u_fifo (
                .clk           (clk),
                .rst_n         (rst_n),
                .push_i        (pulse_i[g]),
                .sec_i         (tb_sec_i),
                .cyc_i         (tb_cyc_i),
                .latch_i       (latch[g]),
                .pop_i         (pop[g]),
                .ovf_clr_i     (ovf_clr[g]),
                .head_sec_lo_o (head_lo[g]),
                .snap_sec_hi_o (snap_hi[g]),
                .snap_cyc_o    (snap_cyc[g]),
                .count_o       (cnt[g]),
                .ovf_o         (ovf[g]),
                .nonempty_o    (nonempty[g])
            );
        end
    endgenerate

    pst_irq_ctrl #(.NUM_CH(NUM_CH)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_we_i    (en_we),
        .en_wdata_i (en_wdata),
        .nonempty_i (nonempty),
        .mask_o     (mask),
        .pend_o     (pend),
        .irq_o      (irq_o)
    );

    pst_reg_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_i       (reg_rd_i),
        .wr_i       (reg_wr_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .head_lo_i  (head_lo),
        .snap_hi_i  (snap_hi),
        .snap_cyc_i (snap_cyc),
        .count_i    (cnt),
        .ovf_i      (ovf),
        .mask_i     (mask),
        .pend_i     (pend),
        .latch_o    (latch),
        .pop_o      (pop),
        .ovf_clr_o  (ovf_clr),
        .en_we_o    (en_we),
        .en_wdata_o (en_wdata),
        .rdata_o    (reg_rdata_o)
    );

endmodule

// File: tb/pulse_stamp_fifos_tb.sv
module pulse_stamp_fifos_tb;
    localparam int NCH = 5, DEPTH = 16, SEC_W = 40, CYC_W = 28, EW = SEC_W + CYC_W;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst_n;
    logic [NCH-1:0]  pulse;
    logic [SEC_W-1:0] tb_sec, tsec;
    logic [CYC_W-1:0] tb_cyc, tcyc;
    logic [7:0]      reg_addr;
    logic            reg_wr, reg_rd, irq;
    logic [31:0]     reg_wdata, reg_rdata, last_rdata;

    pulse_stamp_fifos u_dut (
        .clk(clk), .rst_n(rst_n), .pulse_i(pulse), .tb_sec_i(tb_sec), .tb_cyc_i(tb_cyc),
        .reg_addr_i(reg_addr), .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata),
        .reg_rd_i(reg_rd), .reg_rdata_o(reg_rdata), .irq_o(irq)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [EW-1:0]  expq [NCH][$];
    logic [NCH-1:0] mdl_ovf;
    logic [EW-1:0]  popped;

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus; updates the scoreboard model
    task automatic cyc(input logic [NCH-1:0] pm, input logic rd, input logic wr,
                       input logic [7:0] a, input logic [31:0] wd);
        @(negedge clk);
        last_rdata = reg_rdata;
        if (tcyc == CYC_W'(124)) begin tcyc = '0; tsec = tsec + 1'b1; end
        else tcyc = tcyc + 1'b1;
        tb_sec = tsec; tb_cyc = tcyc;
        pulse = pm; reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wd;
        if (a[7:4] >= 4'd1 && a[7:4] <= 4'(NCH)) begin
            int c = int'(a[7:4]) - 1;
            if (rd && a[3:2] == 2'd2) begin
                if (expq[c].size() > 0) popped = expq[c].pop_front();
                else popped = '0;
            end
            if (wr && a[3:2] == 2'd3 && wd[8]) mdl_ovf[c] = 1'b0;
        end
        for (int c = 0; c < NCH; c++) begin
            if (pm[c]) begin
                if (expq[c].size() < DEPTH) expq[c].push_back({tsec, tcyc});
                else mdl_ovf[c] = 1'b1;
            end
        end
    endtask

    task automatic idle();
        cyc('0, 1'b0, 1'b0, 8'h00, 32'h0);
    endtask

    task automatic rdreg(input logic [7:0] a, output logic [31:0] d);
        cyc('0, 1'b1, 1'b0, a, 32'h0);
        idle();
        d = last_rdata;
    endtask

    task automatic wrreg(input logic [7:0] a, input logic [31:0] d);
        cyc('0, 1'b0, 1'b1, a, d);
    endtask

    // Monitor: reads one record and compares against the popped expectation
    task automatic read_entry(input int c, input logic [NCH-1:0] pm_at_pop, input string req);
        logic [7:0]  base;
        logic [31:0] lo, hi, cy;
        base = 8'((c + 1) * 16);
        cyc('0, 1'b1, 1'b0, base, 32'h0);
        cyc('0, 1'b1, 1'b0, base + 8'h4, 32'h0);
        lo = last_rdata;
        cyc(pm_at_pop, 1'b1, 1'b0, base + 8'h8, 32'h0);
        hi = last_rdata;
        idle();
        cy = last_rdata;
        chk(req, $sformatf("ch%0d seconds", c), {hi, lo}, 64'(popped[EW-1:CYC_W]));
        chk(req, $sformatf("ch%0d cycles", c), 64'(cy), 64'(popped[CYC_W-1:0]));
    endtask

    task automatic check_status(input int c, input string req);
        logic [31:0] d;
        rdreg(8'((c + 1) * 16 + 12), d);
        chk(req, $sformatf("ch%0d status", c), 64'(d),
            64'({23'b0, mdl_ovf[c], 8'(expq[c].size())}));
    endtask

    task automatic drain(input int c, input string req);
        while (expq[c].size() > 0) read_entry(c, '0, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        rst_n = 1'b0; pulse = '0; reg_rd = 0; reg_wr = 0; reg_addr = '0; reg_wdata = '0;
        tsec = 40'h5A_0000_FFF0; tcyc = '0; tb_sec = tsec; tb_cyc = tcyc;
        mdl_ovf = '0; popped = '0;
        repeat (3) idle();
        rst_n = 1'b1;
        idle();
        // R8 reset state
        chk("R8", "irq", 64'(irq), 64'd0);
        chk("R8", "rdata", 64'(reg_rdata), 64'd0);
        for (int c = 0; c < NCH; c++) check_status(c, "R8");
        rdreg(8'h04, d); chk("R8", "mask", 64'(d), 64'd0);

        // R5 enable register and mask view
        wrreg(8'h00, 32'h1);
        rdreg(8'h04, d); chk("R5", "mask", 64'(d), 64'h1);

        // R6 / R5 single pulse on channel 0
        cyc(5'b00001, 0, 0, 8'h00, 0);
        idle();
        chk("R6", "irq after ch0 pulse", 64'(irq), 64'd1);
        rdreg(8'h08, d); chk("R5", "pending", 64'(d), 64'h1);
        check_status(0, "R2");
        // R11 read data holds while idle
        idle(); idle();
        chk("R11", "rdata hold", 64'(reg_rdata), 64'(d));

        // R7 back-to-back pulses on channel 2 (disabled)
        repeat (5) cyc(5'b00100, 0, 0, 8'h00, 0);
        check_status(2, "R7");
        rdreg(8'h08, d); chk("R5", "pending", 64'(d), 64'h5);
        drain(0, "R3");
        idle();
        chk("R6", "irq with only disabled data", 64'(irq), 64'd0);
        wrreg(8'h00, 32'h4);
        idle();
        chk("R6", "irq after enabling ch2", 64'(irq), 64'd1);
        drain(2, "R7");
        idle();
        chk("R6", "irq after drain", 64'(irq), 64'd0);

        // R1 simultaneous and independent channels
        cyc(5'b11111, 0, 0, 8'h00, 0);
        idle();
        cyc(5'b01010, 0, 0, 8'h00, 0);
        cyc(5'b10001, 0, 0, 8'h00, 0);
        for (int c = 0; c < NCH; c++) check_status(c, "R1");
        for (int c = 0; c < NCH; c++) drain(c, "R1");

        // R4 overflow
        repeat (DEPTH + 3) cyc(5'b00010, 0, 0, 8'h00, 0);
        check_status(1, "R4");
        wrreg(8'h2C, 32'h100);
        check_status(1, "R4");
        // R10 pop and push together when full
        read_entry(1, 5'b00010, "R10");
        check_status(1, "R10");
        drain(1, "R10");

        // R9 read of empty queue
        popped = '1;
        read_entry(3, '0, "R9");
        check_status(3, "R9");

        // R6 disable drops irq
        wrreg(8'h00, 32'h1F);
        cyc(5'b10000, 0, 0, 8'h00, 0);
        idle();
        chk("R6", "irq ch4", 64'(irq), 64'd1);
        wrreg(8'h00, 32'h0);
        idle();
        chk("R6", "irq after disable", 64'(irq), 64'd0);
        rdreg(8'h04, d); chk("R5", "mask cleared", 64'(d), 64'h0);
        drain(4, "R3");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule